// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block sits between an internal bus and an external-bus cycle controller. It holds a small table of address regions: each region has a base register, a mask register carrying a valid bit, and a control word. Every cycle it compares the presented lookup address against all regions at once. It then reports which external chip-select line to drive, as a one-hot vector. It also returns the control word of the chosen region, so the cycle controller knows the port width, wait states, acknowledge mode, lane shift and address setup to use.

Regions are aligned to 64 KB and sized in powers of two. A 16-bit mask field applies only to the upper half of the address, and the lower 16 address bits never take part in the comparison. The table is programmed through a one-word write port.

Region 0 has a boot role. Until its valid bit is set, it claims every address, so a boot device can be reached with an unconfigured table. While region 0 holds that role, every other region is held off.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset, every lookup address selects region 0 (`csSel` = 1, `csHit` = 1, `csMiss` = 0). The output control word is 0x07F, meaning auto-acknowledge on, 63 wait states, port size 0, no lane shift and setup 0.
- R2: While region 0's valid bit is clear, region 0 is selected for every address, even when another region is valid and matches.
- R3: The mask field is written from data bits 31:16 of a mask write (select code 1) and applies to address bits 31:16. Address bits 15:0 are always ignored. An address matches a region when, in every upper bit where the mask is 0, it equals the base. For example, base 0x60000000 with mask field 0x0007 covers 0x60000000 to 0x6007FFFF.
- R4: The valid bit is data bit 0 of a mask write. A region whose valid bit is clear never matches.
- R5: When several valid regions match, only the lowest-numbered one is selected, and at most one `csSel` bit is ever set.
- R6: When region 0 is valid and no valid region matches, `csSel` is all zero, `csHit` is 0, `csMiss` is 1 and `csCtrl` is 0.
- R7: A base write (select code 0) keeps only data bits 31:16. The low half of the base is always zero, so a region always starts on a 64 KB boundary.
- R8: A control write (select code 2) stores data bits 11:0. The layout is: bit 0 auto-acknowledge, bits 6:1 wait states, bits 8:7 port size (1 = 8-bit, 2 = 16-bit, 0 or 3 = 32-bit), bit 9 lane shift, bits 11:10 address setup. `csCtrl` carries these bits for the selected region.
- R9: A write whose region index is not below the region count, or whose select code is 3, changes nothing.
- R10: The outputs follow `lookupAddr` in the same cycle. A write takes effect from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrRegion | input | 3 | Region index of the write |
| wrSel | input | 2 | Target register: 0 base, 1 mask/valid, 2 control, 3 none |
| wrData | input | 32 | Write data |
| lookupAddr | input | 32 | Address to decode |
| csSel | output | 6 | One-hot chip-select vector |
| csHit | output | 1 | A region was selected |
| csMiss | output | 1 | No region was selected |
| csCtrl | output | 12 | Control word of the selected region, 0 on a miss |

## Verification
The bench targets overlapping regions. A decoder with the wrong priority would select a higher-numbered region, or raise two select lines at once.

It also probes the exact edges of a mask window: 0x6007FFFF must hit and 0x60080000 must miss. An off-by-one in where the mask field sits, or letting low address bits into the compare, would show up as a wrong hit or a wrong miss there.

The boot behaviour of region 0 is tested by making another region valid before region 0. A design that ignores the boot role would select that other region.

Base writes with non-zero low bits, and writes with an out-of-range index or select code 3, are mixed in. These would expose a decoder that stores unaligned bases or lets a stray write corrupt a region.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int unsigned REGION_IDX_W = 3;

  // Per-region control word; bit order matches the write data layout
  typedef struct packed {
    logic [1:0] addrSetup;
    logic       laneShift;
    logic [1:0] portSize;
    logic [5:0] waitStates;
    logic       autoAck;
  } csCtrl_t;

  localparam int unsigned CTRL_W = $bits(csCtrl_t);

  localparam csCtrl_t CTRL_RESET = '{
    addrSetup:  2'd0,
    laneShift:  1'b0,
    portSize:   2'd0,
    waitStates: 6'h3F,
    autoAck:    1'b1
  };

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  // Qualified write strobe from control to datapath
  typedef struct packed {
    logic                    we;
    logic [REGION_IDX_W-1:0] region;
    regSel_t                 sel;
  } cfgStrobe_t;

endpackage

// File: rtl/csdec_ctl.sv
module csdec_ctl
  import csdec_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [REGION_IDX_W-1:0] wrRegion,
  input  logic [1:0]              wrSel,
  input  logic [NUM_REGIONS-1:0]  rawHit,
  input  logic                    region0Valid,
  output cfgStrobe_t              strobe,
  output logic [NUM_REGIONS-1:0]  csSel,
  output logic                    csHit,
  output logic                    csMiss
);

  logic regionInRange;
  logic selIsReal;

  assign regionInRange = (int'(wrRegion) < int'(NUM_REGIONS));
  assign selIsReal     = (wrSel != SEL_NONE);

  always_comb begin
    strobe.we     = wrEn && regionInRange && selIsReal;
    strobe.region = wrRegion;
    strobe.sel    = regSel_t'(wrSel);
  end

  // Boot role of region 0, otherwise lowest matching index wins
  always_comb begin
    csSel = '0;
    if (!region0Valid) begin
      csSel[0] = 1'b1;
    end else begin
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
        if (rawHit[i]) begin
          csSel    = '0;
          csSel[i] = 1'b1;
        end
      end
    end
  end

  assign csHit  = |csSel;
  assign csMiss = ~csHit;

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSel)); // R5

  AST_HIT_WHEN_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (region0Valid && (rawHit != '0)) |-> csHit); // R3

endmodule

// File: rtl/csdec_path.sv
module csdec_path
  import csdec_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 6,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      lookupAddr,
  input  logic [NUM_REGIONS-1:0] csSel,
  output logic [NUM_REGIONS-1:0] rawHit,
  output logic                   region0Valid,
  output csCtrl_t                ctrlOut
);

  localparam int unsigned LOW_W = ADDR_W / 2;
  localparam int unsigned HI_W  = ADDR_W - LOW_W;

  logic [HI_W-1:0]      baseHi  [NUM_REGIONS];
  logic [HI_W-1:0]      maskFld [NUM_REGIONS];
  logic                 validQ  [NUM_REGIONS];
  csCtrl_t              ctrlQ   [NUM_REGIONS];
  logic [HI_W-1:0]      addrHi;
  logic [NUM_REGIONS*CTRL_W-1:0] ctrlTerms;

  assign addrHi = lookupAddr[ADDR_W-1:LOW_W];

  generate
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
      logic hitMe;
      assign hitMe = strobe.we && (int'(strobe.region) == i);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseHi[i]  <= '0;
          maskFld[i] <= '0;
          validQ[i]  <= 1'b0;
          ctrlQ[i]   <= CTRL_RESET;
        end else if (hitMe) begin
          case (strobe.sel)
            SEL_BASE: baseHi[i] <= wrData[ADDR_W-1:LOW_W];
            SEL_MASK: begin
              maskFld[i] <= wrData[ADDR_W-1:LOW_W];
              validQ[i]  <= wrData[0];
            end
            SEL_CTRL: ctrlQ[i] <= csCtrl_t'(wrData[CTRL_W-1:0]);
            default:  ;
          endcase
        end
      end

      assign rawHit[i] = validQ[i] &&
                         (((addrHi ^ baseHi[i]) & ~maskFld[i]) == '0);

      assign ctrlTerms[i*CTRL_W +: CTRL_W] = ctrlQ[i] & {CTRL_W{csSel[i]}};
    end
  endgenerate

  always_comb begin
    ctrlOut = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      ctrlOut = ctrlOut | ctrlTerms[i*CTRL_W +: CTRL_W];
    end
  end

  assign region0Valid = validQ[0];

  logic unusedLowBits;
  generate
    if (CTRL_W < LOW_W) begin : g_unused_mid
      assign unusedLowBits = ^{wrData[LOW_W-1:CTRL_W], lookupAddr[LOW_W-1:0]};
    end else begin : g_unused_lo
      assign unusedLowBits = ^lookupAddr[LOW_W-1:0];
    end
  endgenerate

  AST_STROBE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |-> ((int'(strobe.region) < int'(NUM_REGIONS)) && (strobe.sel != SEL_NONE))); // R9

  AST_BOOT_REGION0: assert property (@(posedge clk) disable iff (!rstN)
    !validQ[0] |-> (csSel == NUM_REGIONS'(1))); // R2

  AST_SEL_IS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    validQ[0] |-> ((csSel & rawHit) == csSel)); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    validQ[0] |-> (((csSel - NUM_REGIONS'(1)) & rawHit & {NUM_REGIONS{csSel != '0}}) == '0)); // R5

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csdec_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 6,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [REGION_IDX_W-1:0] wrRegion,
  input  logic [1:0]              wrSel,
  input  logic [ADDR_W-1:0]       wrData,
  input  logic [ADDR_W-1:0]       lookupAddr,
  output logic [NUM_REGIONS-1:0]  csSel,
  output logic                    csHit,
  output logic                    csMiss,
  output logic [CTRL_W-1:0]       csCtrl
);

  cfgStrobe_t             strobe;
  logic [NUM_REGIONS-1:0] rawHit;
  logic                   region0Valid;
  csCtrl_t                ctrlOut;

  csdec_ctl #(.NUM_REGIONS(NUM_REGIONS)) i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrRegion     (wrRegion),
    .wrSel        (wrSel),
    .rawHit       (rawHit),
    .region0Valid (region0Valid),
    .strobe       (strobe),
    .csSel        (csSel),
    .csHit        (csHit),
    .csMiss       (csMiss)
  );

  csdec_path #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .lookupAddr   (lookupAddr),
    .csSel        (csSel),
    .rawHit       (rawHit),
    .region0Valid (region0Valid),
    .ctrlOut      (ctrlOut)
  );

  assign csCtrl = ctrlOut;

  logic badWrite;
  assign badWrite = wrEn && ((int'(wrRegion) >= int'(NUM_REGIONS)) || (wrSel == 2'd3));

  AST_MISS_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    csMiss |-> (csCtrl == '0)); // R6

  AST_BAD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(badWrite) && $stable(lookupAddr)) |-> ($stable(csSel) && $stable(csCtrl))); // R9

endmodule

// File: tb/test_chip_select_decoder.sv
`timescale 1ns/1ps
module test_chip_select_decoder;

  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrRegion = '0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] lookupAddr = '0;
  logic [N-1:0] csSel;
  logic        csHit;
  logic        csMiss;
  logic [11:0] csCtrl;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] mBase [N];
  logic [15:0] mMask [N];
  bit          mValid[N];
  logic [11:0] mCtrl [N];

  chip_select_decoder i_chip_select_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRegion(wrRegion), .wrSel(wrSel),
    .wrData(wrData), .lookupAddr(lookupAddr), .csSel(csSel), .csHit(csHit),
    .csMiss(csMiss), .csCtrl(csCtrl)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mBase[i] = 0; mMask[i] = 0; mValid[i] = 0; mCtrl[i] = 12'h07F;
      end
    end else if (wrEn && wrRegion < N) begin
      case (wrSel)
        2'd0: mBase[wrRegion] = wrData & 32'hFFFF_0000;
        2'd1: begin mMask[wrRegion] = wrData[31:16]; mValid[wrRegion] = wrData[0]; end
        2'd2: mCtrl[wrRegion] = wrData[11:0];
        default: ;
      endcase
    end
  end

  function automatic int expIndex(input logic [31:0] a);
    logic [31:0] m;
    if (!mValid[0]) return 0;
    for (int i = 0; i < N; i++) begin
      m = {mMask[i], 16'hFFFF};
      if (mValid[i] && (((a ^ mBase[i]) & ~m) == 0)) return i;
    end
    return -1;
  endfunction

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      int idx;
      logic [N-1:0] eSel;
      logic [11:0] eCtrl;
      idx = expIndex(lookupAddr);
      eSel = (idx < 0) ? '0 : N'(1) << idx;
      eCtrl = (idx < 0) ? 12'h0 : mCtrl[idx];
      checks++;
      if (csSel !== eSel || csHit !== (idx >= 0) || csMiss !== (idx < 0) || csCtrl !== eCtrl) begin
        fails++;
        $display("FAIL %s addr=%h sel=%b hit=%b miss=%b ctrl=%h expected sel=%b hit=%b ctrl=%h",
                 curReq, lookupAddr, csSel, csHit, csMiss, csCtrl, eSel, idx >= 0, eCtrl);
      end
    end
  end

  task automatic doWrite(input logic [2:0] r, input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1; wrRegion = r; wrSel = s; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic expectSel(input string tag, input logic [31:0] a,
                           input logic [N-1:0] eSel, input logic [11:0] eCtrl);
    @(posedge clk); #1;
    lookupAddr = a;
    @(negedge clk);
    checks++;
    if (csSel !== eSel || csCtrl !== eCtrl) begin
      fails++;
      $display("FAIL %s addr=%h sel=%b ctrl=%h expected sel=%b ctrl=%h",
               tag, a, csSel, csCtrl, eSel, eCtrl);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state, region 0 claims everything
    curReq = "R1";
    expectSel("R1", 32'h1234_5678, 6'b000001, 12'h07F);
    expectSel("R1", 32'hFFFF_FFFF, 6'b000001, 12'h07F);

    // R2: region 2 valid but region 0 still booting
    curReq = "R2";
    doWrite(2, 0, 32'h6000_0000);
    doWrite(2, 1, 32'h0007_0001);
    expectSel("R2", 32'h6000_1000, 6'b000001, 12'h07F);

    // R3/R6: enable region 0 elsewhere, window edges of region 2
    curReq = "R3";
    doWrite(0, 0, 32'hA000_0000);
    doWrite(0, 1, 32'h0000_0001);
    doWrite(2, 2, 32'h0000_0000);
    expectSel("R3", 32'h6000_1000, 6'b000100, 12'h000);
    expectSel("R3", 32'h6007_FFFF, 6'b000100, 12'h000);
    curReq = "R6";
    expectSel("R6", 32'h6008_0000, 6'b000000, 12'h000);
    expectSel("R3", 32'hA000_FFFF, 6'b000001, 12'h07F);
    expectSel("R6", 32'hA001_0000, 6'b000000, 12'h000);

    // R7/R5: unaligned base, overlap with region 2
    curReq = "R7";
    doWrite(1, 0, 32'h6000_1234);
    doWrite(1, 1, 32'h0001_0001);
    doWrite(1, 2, 32'h0000_0155);
    expectSel("R7", 32'h6000_0000, 6'b000010, 12'h155);
    curReq = "R5";
    expectSel("R5", 32'h6001_0000, 6'b000010, 12'h155);
    expectSel("R5", 32'h6002_0000, 6'b000100, 12'h000);

    // R4: invalidate region 1
    curReq = "R4";
    doWrite(1, 1, 32'h0001_0000);
    expectSel("R4", 32'h6001_0000, 6'b000100, 12'h000);

    // R8: control word of region 2
    curReq = "R8";
    doWrite(2, 2, 32'hFFFF_FABC);
    expectSel("R8", 32'h6000_4000, 6'b000100, 12'hABC);

    // R9: ignored writes
    curReq = "R9";
    doWrite(6, 1, 32'hFFFF_0001);
    doWrite(7, 0, 32'h6000_0000);
    doWrite(2, 3, 32'h0000_0000);
    expectSel("R9", 32'h6000_4000, 6'b000100, 12'hABC);
    expectSel("R9", 32'h6008_0000, 6'b000000, 12'h000);

    // R10: write visible only after its edge
    curReq = "R10";
    @(posedge clk); #1;
    lookupAddr = 32'h6000_4000;
    wrEn = 1; wrRegion = 2; wrSel = 2; wrData = 32'h0000_0123;
    @(negedge clk);
    checks++;
    if (csCtrl !== 12'hABC) begin
      fails++;
      $display("FAIL R10 ctrl=%h expected %h", csCtrl, 12'hABC);
    end
    @(posedge clk); #1; wrEn = 0;
    @(negedge clk);
    checks++;
    if (csCtrl !== 12'h123) begin
      fails++;
      $display("FAIL R10 ctrl=%h expected %h", csCtrl, 12'h123);
    end

    // mixed traffic against the reference model
    curReq = "R3";
    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #1;
      if ($urandom % 4 == 0) begin
        logic [15:0] hi;
        wrEn = 1;
        wrRegion = 3'($urandom % 8);
        wrSel = 2'($urandom % 4);
        case ($urandom % 4)
          0: hi = 16'h6000; 1: hi = 16'h6001; 2: hi = 16'h6002; default: hi = 16'hA000;
        endcase
        wrData = (wrSel == 2'd1) ? {16'($urandom % 8), 15'($urandom), 1'($urandom)}
                                 : {hi, 16'($urandom)};
      end else begin
        wrEn = 0;
      end
      lookupAddr = ($urandom % 2) ? {16'h6000 + 16'($urandom % 12), 16'($urandom)} : $urandom;
    end
    @(posedge clk); #1; wrEn = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule